// File: doc/BRIEF.md
# Clocked Read Port for a Two-Phase Handshake Pipe

This block is the receiving end of a self-timed pipeline that signals with two-phase (toggle) handshakes. The final stage presents a data word and flips its request line. The port brings that request into the read clock domain and reports a waiting word on a ready flag. When the consumer takes the word, the port flips its acknowledge line back to the request level. That frees the upstream stage to deliver the next word.

A word is waiting exactly when the synchronized request level and the acknowledge level differ. A transfer happens on each rising read-clock edge where ready and the read enable are both high. The request passes through a two-flop synchronizer. The data word is captured into the output register on the same edge that ready rises. The upstream side must therefore hold the data stable from its request toggle until the acknowledge answers.

Top module: `tp_read_port`

## Requirements
- R1: While reset is asserted (`rst_n` low), `ack_tgl` is 0, `rd_rdy` is 0 and `rd_data` is all zeros.
- R2: After `req_tgl` changes level while no word is pending, `rd_rdy` is still low after the first rising edge and high after the second. This holds for a rising toggle and for a falling toggle alike.
- R3: On the edge where `rd_rdy` rises, `rd_data` takes the word that was on `req_data` when the request toggled.
- R4: On a rising edge with `rd_rdy` and `rd_en` both high, `ack_tgl` flips so that it equals the request level again. With no newer request, `rd_rdy` is low after that edge.
- R5: While `rd_rdy` is low, `rd_en` has no effect: `ack_tgl` and `rd_data` stay unchanged.
- R6: While `rd_rdy` is high and `rd_en` is low, `rd_rdy`, `ack_tgl` and `rd_data` hold, even if `req_data` changes.
- R7: With `rd_en` held high and an upstream that answers each acknowledge within half a clock, one word is delivered every three clocks, in order and without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| req_tgl | input | 1 | Two-phase request from the last pipeline stage (asynchronous) |
| req_data | input | DATA_W | Word offered by the last pipeline stage |
| rd_en | input | 1 | Consumer enable |
| rd_rdy | output | 1 | A word is waiting on `rd_data` |
| rd_data | output | DATA_W | Word presented to the consumer |
| ack_tgl | output | 1 | Two-phase acknowledge back to the pipeline |

## Verification
A request toggle that the bench drives at a falling edge appears on `rd_rdy` and `rd_data` after exactly the second following rising edge. A transfer shows on `ack_tgl` and `rd_rdy` after the single rising edge where it happens. The directed tasks drive all inputs at falling edges. Each task counts rising edges from its stimulus and samples outputs at the next falling edge: one edge for transfer results, two for arrival results. It also checks the intermediate edge, so an early response fails just as a late one does. The streaming task counts the clocks between acknowledge flips to confirm the three-cycle cadence.

// File: rtl/tp_read_port.sv
module tp_read_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic [DATA_W-1:0] req_data,
  input  logic              rd_en,
  output logic              rd_rdy,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_tgl
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]       sync_q;
  logic                ack_q;
  logic [DATA_W-1:0]   data_q;

  wire req_s   = sync_q[LAST];
  wire req_pre = sync_q[LAST-1];
  wire take    = rd_rdy & rd_en;
  wire ack_nxt = take ? req_s : ack_q;
  wire stall   = rd_rdy & ~take;
  wire load    = (req_pre ^ ack_nxt) & ~stall;

  assign rd_rdy  = req_s ^ ack_q;
  assign rd_data = data_q;
  assign ack_tgl = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], req_tgl};
      ack_q  <= ack_nxt;
      if (load) data_q <= req_data;
    end
  end

endmodule

module tp_read_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_tgl,
  input logic              rd_en,
  input logic              rd_rdy,
  input logic [DATA_W-1:0] rd_data,
  input logic              ack_tgl
);

  a_r4_ack_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rdy && rd_en) |=> (ack_tgl != $past(ack_tgl)));

  a_r5_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_rdy && rd_en) |=> $stable(ack_tgl));

  a_r5_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rdy && $past(!rd_rdy)) |=> (rd_rdy || $stable(rd_data)));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rdy && !rd_en) |=> (rd_rdy && $stable(rd_data)));

  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_rdy) |-> ($past(req_tgl, 2) != ack_tgl));

endmodule

bind tp_read_port tp_read_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl), .rd_en(rd_en),
  .rd_rdy(rd_rdy), .rd_data(rd_data), .ack_tgl(ack_tgl)
);

// File: tb/tp_read_port_tb.sv
module tp_read_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_tgl = 1'b0;
  logic [W-1:0] req_data = '0;
  logic         rd_en = 1'b0;
  logic         rd_rdy;
  logic [W-1:0] rd_data;
  logic         ack_tgl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tp_read_port #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl), .req_data(req_data),
    .rd_en(rd_en), .rd_rdy(rd_rdy), .rd_data(rd_data), .ack_tgl(ack_tgl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] w);
    req_data = w;
    req_tgl  = ~req_tgl;
  endtask

  task automatic t_reset;
    chk("R1 rdy", rd_rdy, 0);
    chk("R1 ack", ack_tgl, 0);
    chk("R1 data", rd_data, 0);
  endtask

  task automatic arrive(input logic [W-1:0] w);
    logic [W-1:0] old = rd_data;
    push(w);
    edges(1);
    chk("R2 rdy after 1 edge", rd_rdy, 0);
    chk("R3 data not early", rd_data, old);
    edges(1);
    chk("R2 rdy after 2 edges", rd_rdy, 1);
    chk("R3 data on rise", rd_data, w);
  endtask

  task automatic consume;
    rd_en = 1'b1;
    edges(1);
    rd_en = 1'b0;
    chk("R4 ack equals req", ack_tgl, req_tgl);
    chk("R4 rdy falls", rd_rdy, 0);
  endtask

  task automatic t_single;
    logic a0;
    arrive(8'hA5);
    a0 = ack_tgl;
    for (int i = 0; i < 3; i++) begin
      req_data = 8'h10 + 8'(i);
      edges(1);
      chk("R6 rdy holds", rd_rdy, 1);
      chk("R6 ack holds", ack_tgl, a0);
      chk("R6 data holds", rd_data, 8'hA5);
    end
    req_data = 8'hA5;
    consume();
  endtask

  task automatic t_idle_enable;
    logic a0 = ack_tgl;
    logic [W-1:0] d0 = rd_data;
    rd_en = 1'b1;
    req_data = 8'h3C;
    for (int i = 0; i < 3; i++) begin
      edges(1);
      chk("R5 ack unchanged", ack_tgl, a0);
      chk("R5 data unchanged", rd_data, d0);
    end
    rd_en = 1'b0;
  endtask

  task automatic t_falling;
    chk("R2 req level before", req_tgl, 1);
    arrive(8'h5A);
    consume();
  endtask

  task automatic t_stream;
    logic a_prev;
    int gap;
    rd_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] w = 8'(8'hC0 + k * 7);
      a_prev = ack_tgl;
      push(w);
      gap = 0;
      while (ack_tgl == a_prev && gap < 10) begin
        edges(1);
        gap++;
        if (gap == 2) chk("R7 word in order", rd_data, w);
      end
      chk("R7 three clocks per word", gap, 3);
      chk("R7 ack matches req", ack_tgl, req_tgl);
    end
    rd_en = 1'b0;
    edges(1);
    chk("R7 drained", rd_rdy, 0);
  endtask

  initial begin
    edges(2);
    t_reset();
    rst_n = 1'b1;
    edges(2);
    t_single();
    t_idle_enable();
    t_falling();
    t_stream();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule